// File: doc/BRIEF.md
# Power-Down Calibration Trigger Sequencer

This block sits between a combined power-down/calibrate control pin and the loop-gain self-calibration engine of a clock-recovery loop. It brings the asynchronous pin into the system clock domain and reports the power-down state while the pin is high. It then decides whether a high-to-low transition of the pin should launch a calibration. A falling edge counts only when the pin stayed high for a qualified minimum time. The minimum is given in nanoseconds and converted into clock cycles from the system clock frequency.

A calibration also needs a valid reference clock. If the reference is missing when a qualified edge arrives, the request is held pending and is launched once the reference becomes valid. A new power-down cancels the pending request. After launch, a busy flag stays up until the calibration engine reports completion. Throughout power-down, a pending request and calibration, the block holds a mask that keeps the loss-of-lock alarm quiet. All pins are plain level or pulse signals with no handshake. The reference-valid and done inputs are expected to be synchronous to the system clock.

Top module: `pdcal_seq`

## Requirements
- R1: After reset, pd_active, cal_start, cal_busy and lol_mask are all 0.
- R2: pd_active equals the level of pd_cal_raw delayed by two rising clock edges (two-flop synchroniser): it is 0 one edge after the raw pin rises and 1 two edges after.
- R3: With QUAL_CYCLES = ceil(CLK_MHZ*MIN_HIGH_NS/1000) (100 for the defaults), a falling edge after the synchronised pin was high for at least QUAL_CYCLES cycles, with ref_ok high, makes cal_start 1 after the third rising edge following the raw pin's fall.
- R4: A high period shorter than QUAL_CYCLES cycles does not start a calibration. The next high period counts from zero.
- R5: If ref_ok is low at a qualified falling edge, no start occurs and the request stays pending. cal_start pulses on the first rising edge at which ref_ok is sampled high.
- R6: A pending request is dropped if the synchronised pin goes high again before ref_ok is valid. No start follows unless a new qualified falling edge occurs.
- R7: cal_busy rises together with cal_start and stays 1 until cal_done is sampled high. It is 0 after that edge.
- R8: Qualified falling edges that arrive while cal_busy is 1 are ignored and start nothing, then or later.
- R9: lol_mask is 1 whenever pd_active is 1, a request is pending, or cal_busy is 1. It is 0 otherwise.
- R10: cal_start is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of known frequency |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_cal_raw | input | 1 | Raw power-down/calibrate pin, asynchronous |
| ref_ok | input | 1 | Reference clock valid flag, synchronous |
| cal_done | input | 1 | Calibration engine finished, synchronous |
| pd_active | output | 1 | Synchronised power-down state |
| cal_start | output | 1 | One-cycle calibration launch pulse |
| cal_busy | output | 1 | Calibration in progress |
| lol_mask | output | 1 | Hold the loss-of-lock alarm deasserted |

## Verification
The bench aims at the qualification boundary. High periods of exactly QUAL_CYCLES-1 and QUAL_CYCLES cycles separate a counter that compares off by one, which would launch on the short pulse or miss the exact one. Falls with the reference missing check that the request waits and launches on the exact cycle the reference arrives. A power-down that interrupts the wait checks the cancel path, since a design that forgets to cancel would launch a spurious calibration. Falls during a busy calibration check for a design that re-arms or queues a second start. Random high lengths around the threshold, together with a random reference state, are compared against a bench function of the high time.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_REF = 2'd1,
    ST_CAL      = 2'd2
  } cal_state_t;

  // Cycles needed to cover min_ns at clk_mhz, rounded up.
  function automatic int qual_cycles(input int clk_mhz, input int min_ns);
    return (clk_mhz * min_ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/pdcal_sync.sv
module pdcal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pdcal_qual.sv
module pdcal_qual #(
  parameter int QUAL_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall_ok
);
  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYCLES);

  logic [CW-1:0] hi_cnt;
  logic          lvl_d;

  // Count cycles of high level, saturate at the limit, clear when low.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lvl_d  <= 1'b0;
    end else begin
      lvl_d <= lvl;
      if (!lvl)              hi_cnt <= '0;
      else if (hi_cnt != LIMIT) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assign fall_ok = lvl_d && !lvl && (hi_cnt == LIMIT);

  // R4
  qual_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && !lvl_d) |=> !fall_ok);
endmodule

// File: rtl/pdcal_fsm.sv
module pdcal_fsm
  import pdcal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_lvl,
  input  logic fall_ok,
  input  logic ref_ok,
  input  logic cal_done,
  output logic start_q,
  output logic pending,
  output logic busy
);
  cal_state_t state, nxt;
  logic       go;

  always_comb begin
    nxt = state;
    go  = 1'b0;
    unique case (state)
      ST_IDLE: if (fall_ok) begin
        if (ref_ok) begin nxt = ST_CAL; go = 1'b1; end
        else            nxt = ST_WAIT_REF;
      end
      ST_WAIT_REF: begin
        if (pd_lvl)      nxt = ST_IDLE;
        else if (ref_ok) begin nxt = ST_CAL; go = 1'b1; end
      end
      ST_CAL: if (cal_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      start_q <= 1'b0;
    end else begin
      state   <= nxt;
      start_q <= go;
    end
  end

  assign pending = (state == ST_WAIT_REF);
  assign busy    = (state == ST_CAL);

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cal_done) |=> busy);
  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R5
  start_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(ref_ok));
  // R3
  fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ok |-> !pd_lvl);
endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq
  import pdcal_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int MIN_HIGH_NS = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_cal_raw,
  input  logic ref_ok,
  input  logic cal_done,
  output logic pd_active,
  output logic cal_start,
  output logic cal_busy,
  output logic lol_mask
);
  localparam int QUAL_CYCLES = qual_cycles(CLK_MHZ, MIN_HIGH_NS);

  logic pd_lvl;
  logic fall_ok;
  logic pending;

  pdcal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pd_cal_raw), .q(pd_lvl)
  );

  pdcal_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(rst_n), .lvl(pd_lvl), .fall_ok(fall_ok)
  );

  pdcal_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_lvl(pd_lvl), .fall_ok(fall_ok),
    .ref_ok(ref_ok), .cal_done(cal_done),
    .start_q(cal_start), .pending(pending), .busy(cal_busy)
  );

  assign pd_active = pd_lvl;
  assign lol_mask  = pd_lvl | pending | cal_busy;

  // R9
  mask_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> lol_mask);
  // R9
  mask_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> lol_mask);
endmodule

// File: tb/test_pdcal_seq.sv
module test_pdcal_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int  QUAL = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_cal_raw = 1'b0;
  logic ref_ok = 1'b0;
  logic cal_done = 1'b0;
  logic pd_active, cal_start, cal_busy, lol_mask;

  int checks = 0;
  int fails = 0;
  int starts = 0;

  pdcal_seq i_pdcal_seq (
    .clk(clk), .rst_n(rst_n), .pd_cal_raw(pd_cal_raw), .ref_ok(ref_ok),
    .cal_done(cal_done), .pd_active(pd_active), .cal_start(cal_start),
    .cal_busy(cal_busy), .lol_mask(lol_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n && cal_start) starts++;

  function automatic int expect_start(input int hi_len);
    return (hi_len >= QUAL) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    pd_cal_raw = 1'b1;
    tick(n);
    pd_cal_raw = 1'b0;
  endtask

  task automatic finish_cal();
    cal_done = 1'b1;
    tick(1);
    cal_done = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got 0 expected 1 (run completed)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    int s0;
    void'($urandom(32'd4711));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1
    chk("R1 pd_active", pd_active, 0);
    chk("R1 cal_start", cal_start, 0);
    chk("R1 cal_busy", cal_busy, 0);
    chk("R1 lol_mask", lol_mask, 0);

    // R2: two-edge latency
    pd_cal_raw = 1'b1;
    tick(1);
    chk("R2 one edge", pd_active, 0);
    tick(1);
    chk("R2 two edges", pd_active, 1);
    chk("R9 mask in power-down", lol_mask, 1);
    tick(QUAL);
    pd_cal_raw = 1'b0;
    ref_ok = 1'b1;
    tick(2);
    chk("R2 fall latency", pd_active, 0);
    tick(1);
    // R3 qualified start on third edge
    chk("R3 start pulse", cal_start, 1);
    chk("R7 busy with start", cal_busy, 1);
    tick(1);
    chk("R10 pulse width", cal_start, 0);
    chk("R9 mask while busy", lol_mask, 1);
    tick(5);
    chk("R7 busy held", cal_busy, 1);
    finish_cal();
    chk("R7 busy cleared", cal_busy, 0);
    chk("R9 mask idle", lol_mask, 0);

    // R4: boundary one short
    s0 = starts;
    pulse(QUAL - 1);
    tick(6);
    chk("R4 short pulse", starts - s0, 0);
    // R4: short pulses do not accumulate
    pulse(QUAL / 2);
    tick(1);
    pulse(QUAL / 2 + 5);
    tick(6);
    chk("R4 no accumulation", starts - s0, 0);
    // R3: exact boundary
    pulse(QUAL);
    tick(6);
    chk("R3 exact boundary", starts - s0, 1);
    finish_cal();

    // R5: pending until reference valid
    s0 = starts;
    ref_ok = 1'b0;
    pulse(QUAL + 3);
    tick(10);
    chk("R5 no start without ref", starts - s0, 0);
    chk("R9 mask while pending", lol_mask, 1);
    ref_ok = 1'b1;
    tick(1);
    chk("R5 start on ref", cal_start, 1);
    tick(3);
    chk("R5 single start", starts - s0, 1);
    finish_cal();

    // R6: new power-down cancels pending
    s0 = starts;
    ref_ok = 1'b0;
    pulse(QUAL + 1);
    tick(5);
    pd_cal_raw = 1'b1;
    tick(4);
    ref_ok = 1'b1;
    tick(5);
    pd_cal_raw = 1'b0;
    tick(8);
    chk("R6 cancelled", starts - s0, 0);
    chk("R6 idle mask", lol_mask, 0);

    // R8: falls during busy ignored
    s0 = starts;
    pulse(QUAL);
    tick(6);
    chk("R8 first start", starts - s0, 1);
    pulse(QUAL + 2);
    tick(6);
    pulse(QUAL + 4);
    tick(6);
    chk("R8 ignored while busy", starts - s0, 1);
    chk("R8 still busy", cal_busy, 1);
    finish_cal();
    tick(10);
    chk("R8 nothing queued", starts - s0, 1);

    // Random lengths around threshold, random reference state
    for (int it = 0; it < 40; it++) begin
      int len;
      int refv;
      int exp;
      len  = (($urandom % 4) == 0) ? 1 + ($urandom % 20) : QUAL - 6 + ($urandom % 12);
      refv = $urandom % 2;
      exp  = expect_start(len);
      ref_ok = refv[0];
      s0 = starts;
      pulse(len);
      tick(6);
      if (refv == 1) begin
        chk("R3 random start", starts - s0, exp);
      end else begin
        chk("R5 random hold", starts - s0, 0);
        chk("R9 random mask", lol_mask, exp);
        ref_ok = 1'b1;
        tick(4);
        chk("R5 random release", starts - s0, exp);
      end
      if (exp == 1) begin
        tick($urandom % 5);
        finish_cal();
        chk("R7 random clear", cal_busy, 0);
      end
      tick(1 + ($urandom % 3));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule